// File: doc/BRIEF.md
# Single-Wire Bus Master Slot Timer

This block produces the line timing for the master side of a single-wire, open-drain bus. A higher-level controller gives it one primitive at a time through a valid/ready handshake: a bus reset with presence detection, a one-bit write, a one-bit read, or a strong-pullup hold. The block drives an enable that pulls the shared line low and a separate enable for a strong pull-up transistor. It samples the line through a synchronizer and, when the operation ends, returns either the presence result or the bit that was read.

Every window is given in microseconds as a parameter and turned into clock cycles through the clock-frequency parameter. Byte assembly, command decoding, device search and the decision to start a strong-pullup hold after a conversion or copy command belong to the controller above. That controller must request the hold within 10 µs of the end of such a command byte.

Top module: `sw_slot_engine`

## Requirements
- R1: After reset `ready_o` is 1 and `pull_low_o`, `hold_hi_o` and `done_o` are 0.
- R2: An operation is accepted on a clock edge where `valid_i` and `ready_o` are both 1. `ready_o` is 0 from the next cycle for the whole operation. `done_o` is a one-cycle pulse in the first cycle `ready_o` is 1 again, and the next operation may be accepted in that cycle.
- R3: The reset operation (`cmd_i` = 0) drives `pull_low_o` for RST_LOW_US (500 µs) from the cycle after acceptance. It then releases the line for RST_LISTEN_US (500 µs), so it is busy for 1000 µs in total.
- R4: For the reset operation, `result_o` at `done_o` is 1 only if the synchronized line was seen low in the window from PRES_BEG_US (15 µs) to PRES_END_US (300 µs) after the release. Lows outside that window are ignored.
- R5: A write (`cmd_i` = 1) with `wbit_i` = 1 drives `pull_low_o` for W1_LOW_US (6 µs).
- R6: A write with `wbit_i` = 0 drives `pull_low_o` for W0_LOW_US (64 µs).
- R7: A read (`cmd_i` = 2) drives `pull_low_o` for RD_LOW_US (3 µs). `result_o` is the synchronized line value taken RD_SMP_US (12 µs) after the slot start.
- R8: Each write or read slot keeps the block busy for SLOT_US (70 µs). This leaves at least 1 µs of released line before the next slot.
- R9: The hold operation (`cmd_i` = 3) drives `hold_hi_o` for SPU_US from the cycle after acceptance and does not assert `pull_low_o` during the hold.
- R10: `pull_low_o` and `hold_hi_o` are never 1 together, and neither is 1 while `ready_o` is 1.
- R11: `wbit_i` affects only write slots. A read issued with `wbit_i` = 1 still pulls low for RD_LOW_US only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, frequency CLK_HZ |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation request |
| cmd_i | input | 2 | 0 reset, 1 write, 2 read, 3 strong-pullup hold |
| wbit_i | input | 1 | Bit value for a write |
| ready_o | output | 1 | Engine idle, request can be accepted |
| done_o | output | 1 | One-cycle end-of-operation pulse |
| result_o | output | 1 | Presence (reset) or read bit, valid with done_o |
| line_i | input | 1 | Resolved bus line level |
| pull_low_o | output | 1 | 1 drives the bus line low |
| hold_hi_o | output | 1 | 1 enables the strong pull-up |

## Verification
The end of one operation and the acceptance of the next can fall in the same cycle. The `done_o` pulse, the result of the finished slot and the acceptance edge of the following request all share one cycle. The bench provokes this by raising `valid_i` again in the very cycle that `done_o` is seen, so writes, reads, resets and holds run back to back. Each operation is judged by counting, cycle by cycle, how long the line is pulled low, how long the hold is on and how long `ready_o` stays low. The result of the previous operation must still be intact, and the next slot's pull-low must begin exactly one cycle later.

// File: rtl/sw_slot_pkg.sv
package sw_slot_pkg;
  typedef enum logic [1:0] {
    CMD_RESET = 2'd0,
    CMD_WRITE = 2'd1,
    CMD_READ  = 2'd2,
    CMD_HOLD  = 2'd3
  } sw_cmd_e;

  function automatic int unsigned us2cyc(int unsigned clk_hz, int unsigned us);
    return (clk_hz / 1_000_000) * us;
  endfunction
endpackage

// File: rtl/sw_sync.sv
module sw_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sr_q <= {STAGES{RST_VAL}};
    else         sr_q <= {sr_q[STAGES-2:0], d_i};
  end

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/sw_timer.sv
module sw_timer #(
  parameter int unsigned CW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          run_i,
  output logic [CW-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_o <= '0;
    else if (clear_i) cnt_o <= '0;
    else if (run_i)   cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/sw_slot_fsm.sv
module sw_slot_fsm
  import sw_slot_pkg::*;
#(
  parameter int unsigned CLK_HZ        = 100_000_000,
  parameter int unsigned RST_LOW_US    = 500,
  parameter int unsigned RST_LISTEN_US = 500,
  parameter int unsigned PRES_BEG_US   = 15,
  parameter int unsigned PRES_END_US   = 300,
  parameter int unsigned W1_LOW_US     = 6,
  parameter int unsigned W0_LOW_US     = 64,
  parameter int unsigned RD_LOW_US     = 3,
  parameter int unsigned RD_SMP_US     = 12,
  parameter int unsigned SLOT_US       = 70,
  parameter int unsigned SPU_US        = 10_000,
  parameter int unsigned CW            = 20
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [1:0]    cmd_i,
  input  logic          wbit_i,
  input  logic          line_s_i,
  input  logic [CW-1:0] cnt_i,
  output logic          start_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          result_o,
  output logic          pull_low_o,
  output logic          hold_hi_o
);
  localparam logic [CW-1:0] RST_LOW_C = CW'(us2cyc(CLK_HZ, RST_LOW_US));
  localparam logic [CW-1:0] RST_TOT_C = CW'(us2cyc(CLK_HZ, RST_LOW_US + RST_LISTEN_US));
  localparam logic [CW-1:0] PW_BEG_C  = CW'(us2cyc(CLK_HZ, RST_LOW_US + PRES_BEG_US));
  localparam logic [CW-1:0] PW_END_C  = CW'(us2cyc(CLK_HZ, RST_LOW_US + PRES_END_US));
  localparam logic [CW-1:0] W1_C      = CW'(us2cyc(CLK_HZ, W1_LOW_US));
  localparam logic [CW-1:0] W0_C      = CW'(us2cyc(CLK_HZ, W0_LOW_US));
  localparam logic [CW-1:0] RD_C      = CW'(us2cyc(CLK_HZ, RD_LOW_US));
  localparam logic [CW-1:0] SMP_C     = CW'(us2cyc(CLK_HZ, RD_SMP_US));
  localparam logic [CW-1:0] SLOT_C    = CW'(us2cyc(CLK_HZ, SLOT_US));
  localparam logic [CW-1:0] SPU_C     = CW'(us2cyc(CLK_HZ, SPU_US));

  sw_cmd_e       op_q;
  logic          busy_q, wb_q, done_q, res_q;
  logic [CW-1:0] low_lim, total;
  logic          last, in_win;

  always_comb begin
    unique case (op_q)
      CMD_RESET: begin low_lim = RST_LOW_C;               total = RST_TOT_C; end
      CMD_WRITE: begin low_lim = wb_q ? W1_C : W0_C;      total = SLOT_C;    end
      CMD_READ:  begin low_lim = RD_C;                    total = SLOT_C;    end
      default:   begin low_lim = '0;                      total = SPU_C;     end
    endcase
  end

  assign start_o = valid_i && !busy_q;
  assign last    = busy_q && (cnt_i == total - 1'b1);
  assign in_win  = (cnt_i >= PW_BEG_C) && (cnt_i < PW_END_C);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      op_q   <= CMD_RESET;
      wb_q   <= 1'b0;
      done_q <= 1'b0;
      res_q  <= 1'b0;
    end else begin
      done_q <= last;
      if (start_o) begin
        busy_q <= 1'b1;
        op_q   <= sw_cmd_e'(cmd_i);
        wb_q   <= wbit_i;
        res_q  <= 1'b0;
      end else if (busy_q) begin
        if (last) busy_q <= 1'b0;
        // presence: any low in the listen window
        if (op_q == CMD_RESET && in_win && !line_s_i) res_q <= 1'b1;
        if (op_q == CMD_READ && cnt_i == SMP_C) res_q <= line_s_i;
      end
    end
  end

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign result_o   = res_q;
  assign pull_low_o = busy_q && (op_q != CMD_HOLD) && (cnt_i < low_lim);
  assign hold_hi_o  = busy_q && (op_q == CMD_HOLD);
endmodule

// File: rtl/sw_slot_engine.sv
module sw_slot_engine
  import sw_slot_pkg::*;
#(
  parameter int unsigned CLK_HZ        = 100_000_000,
  parameter int unsigned RST_LOW_US    = 500,
  parameter int unsigned RST_LISTEN_US = 500,
  parameter int unsigned PRES_BEG_US   = 15,
  parameter int unsigned PRES_END_US   = 300,
  parameter int unsigned W1_LOW_US     = 6,
  parameter int unsigned W0_LOW_US     = 64,
  parameter int unsigned RD_LOW_US     = 3,
  parameter int unsigned RD_SMP_US     = 12,
  parameter int unsigned SLOT_US       = 70,
  parameter int unsigned SPU_US        = 10_000,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       valid_i,
  input  logic [1:0] cmd_i,
  input  logic       wbit_i,
  output logic       ready_o,
  output logic       done_o,
  output logic       result_o,
  input  logic       line_i,
  output logic       pull_low_o,
  output logic       hold_hi_o
);
  localparam int unsigned RST_CYC = us2cyc(CLK_HZ, RST_LOW_US + RST_LISTEN_US);
  localparam int unsigned SPU_CYC = us2cyc(CLK_HZ, SPU_US);
  localparam int unsigned MAX_CYC = (RST_CYC > SPU_CYC) ? RST_CYC : SPU_CYC;
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);

  logic          line_s, start, busy;
  logic [CW-1:0] cnt;

  sw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk_i, .rst_ni, .d_i(line_i), .q_o(line_s)
  );

  sw_timer #(.CW(CW)) u_timer (
    .clk_i, .rst_ni, .clear_i(start), .run_i(busy), .cnt_o(cnt)
  );

  sw_slot_fsm #(
    .CLK_HZ(CLK_HZ), .RST_LOW_US(RST_LOW_US), .RST_LISTEN_US(RST_LISTEN_US),
    .PRES_BEG_US(PRES_BEG_US), .PRES_END_US(PRES_END_US),
    .W1_LOW_US(W1_LOW_US), .W0_LOW_US(W0_LOW_US), .RD_LOW_US(RD_LOW_US),
    .RD_SMP_US(RD_SMP_US), .SLOT_US(SLOT_US), .SPU_US(SPU_US), .CW(CW)
  ) u_fsm (
    .clk_i, .rst_ni, .valid_i, .cmd_i, .wbit_i,
    .line_s_i(line_s), .cnt_i(cnt),
    .start_o(start), .busy_o(busy), .done_o, .result_o,
    .pull_low_o, .hold_hi_o
  );

  assign ready_o = !busy;
endmodule

// File: rtl/sw_slot_engine_chk.sv
module sw_slot_engine_chk #(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned RST_LOW_US = 500,
  parameter int unsigned W1_LOW_US  = 6,
  parameter int unsigned W0_LOW_US  = 64,
  parameter int unsigned RD_LOW_US  = 3
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic       ready_o,
  input logic       done_o,
  input logic       pull_low_o,
  input logic       hold_hi_o
);
  localparam int unsigned CPU = CLK_HZ / 1_000_000;
  localparam int unsigned LIM = 1 << 24;

  int unsigned hi_len, lo_len;
  logic        pd_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_len <= 0;
      lo_len <= LIM;
      pd_d   <= 1'b0;
    end else begin
      pd_d   <= pull_low_o;
      hi_len <= pull_low_o ? hi_len + 1 : 0;
      lo_len <= pull_low_o ? 0 : ((lo_len < LIM) ? lo_len + 1 : lo_len);
    end
  end

  p_busy_after_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !ready_o);

  p_done_on_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (ready_o && $past(!ready_o)));

  p_pull_starts_on_accept_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_low_o) |-> $past(valid_i && ready_o));

  p_pull_len_legal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_d && !pull_low_o) |-> (hi_len == CPU*W1_LOW_US || hi_len == CPU*W0_LOW_US ||
                               hi_len == CPU*RD_LOW_US || hi_len == CPU*RST_LOW_US));

  p_recovery_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pull_low_o) |-> (lo_len >= CPU));

  p_hold_starts_on_accept_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(hold_hi_o) |-> $past(valid_i && ready_o));

  p_no_overlap_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pull_low_o && hold_hi_o));

  p_quiet_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (!pull_low_o && !hold_hi_o));
endmodule

bind sw_slot_engine sw_slot_engine_chk #(
  .CLK_HZ(CLK_HZ), .RST_LOW_US(RST_LOW_US), .W1_LOW_US(W1_LOW_US),
  .W0_LOW_US(W0_LOW_US), .RD_LOW_US(RD_LOW_US)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .ready_o(ready_o),
  .done_o(done_o), .pull_low_o(pull_low_o), .hold_hi_o(hold_hi_o)
);

// File: tb/sim_sw_slot_engine.sv
`timescale 1ns/1ps
module sim_sw_slot_engine;
  localparam int T      = 2;      // cycles per microsecond at CLK_HZ = 2 MHz
  localparam int SPU_US = 100;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic valid_i = 1'b0, wbit_i = 1'b0;
  logic [1:0] cmd_i = 2'd0;
  logic ready_o, done_o, result_o, line_i, pull_low_o, hold_hi_o;

  always #2.5 clk_i = ~clk_i;

  sw_slot_engine #(.CLK_HZ(2_000_000), .SPU_US(SPU_US)) u0 (
    .clk_i, .rst_ni, .valid_i, .cmd_i, .wbit_i, .ready_o, .done_o, .result_o,
    .line_i, .pull_low_o, .hold_hi_o
  );

  // slave model: 0 silent, 1 presence pulse, 2 read responder
  int   mode = 0, pres_dly = 0, pres_w = 0;
  logic rd_bit = 1'b1;
  logic pd_q = 1'b0;
  int   since_rel = 100000, since_fall = 100000;
  logic slave_pull;

  always @(posedge clk_i) begin
    pd_q <= pull_low_o;
    since_rel  <= (!pull_low_o && pd_q) ? 0 : since_rel + 1;
    since_fall <= (pull_low_o && !pd_q) ? 0 : since_fall + 1;
  end

  always_comb begin
    slave_pull = 1'b0;
    if (mode == 1 && since_rel >= pres_dly*T && since_rel < (pres_dly+pres_w)*T) slave_pull = 1'b1;
    if (mode == 2 && !rd_bit && since_fall < 30*T) slave_pull = 1'b1;
  end
  assign line_i = !pull_low_o && !slave_pull;

  int errors = 0, checks = 0, idle_bad = 0;
  logic timeout = 1'b0;
  int m_pd, m_busy, m_spu, m_both;
  logic m_res;

  initial begin
    repeat (190000) @(posedge clk_i);
    timeout = 1'b1;
  end

  always @(negedge clk_i) if (rst_ni && ready_o && (pull_low_o || hold_hi_o)) idle_bad++;

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // called at a negedge with ready_o high; returns at the negedge showing done_o
  task automatic run_op(input logic [1:0] c, input logic b);
    valid_i = 1'b1; cmd_i = c; wbit_i = b;
    @(posedge clk_i); @(negedge clk_i);
    valid_i = 1'b0;
    check(ready_o == 1'b0, "R2 ready low after accept", int'(ready_o), 0);
    m_pd = 0; m_busy = 0; m_spu = 0; m_both = 0;
    while (!done_o && !timeout) begin
      if (pull_low_o) m_pd++;
      if (hold_hi_o) m_spu++;
      if (!ready_o) m_busy++;
      if (pull_low_o && hold_hi_o) m_both++;
      @(negedge clk_i);
    end
    m_res = result_o;
    check(ready_o == 1'b1, "R2 ready with done", int'(ready_o), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check(ready_o == 1'b1 && !pull_low_o && !hold_hi_o && !done_o, "R1 reset state",
          {ready_o, pull_low_o, hold_hi_o, done_o}, 4'b1000);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check(ready_o == 1'b1 && !pull_low_o && !hold_hi_o && !done_o, "R1 after release",
          {ready_o, pull_low_o, hold_hi_o, done_o}, 4'b1000);

    // writes back to back
    mode = 0;
    for (int i = 0; i < 4; i++) begin
      logic b;
      b = logic'(i % 2);
      run_op(2'd1, b);
      if (b) check(m_pd == 6*T, "R5 write-1 low time", m_pd, 6*T);
      else   check(m_pd == 64*T, "R6 write-0 low time", m_pd, 64*T);
      check(m_busy == 70*T, "R8 slot length", m_busy, 70*T);
    end

    // reads, slave answering 0 and 1, wbit toggled
    mode = 2;
    for (int i = 0; i < 4; i++) begin
      rd_bit = logic'(i % 2);
      run_op(2'd2, logic'(i / 2));
      check(m_res == rd_bit, "R7 read bit", int'(m_res), int'(rd_bit));
      check(m_pd == 3*T, "R11 read low time independent of wbit", m_pd, 3*T);
      check(m_busy == 70*T, "R8 read slot length", m_busy, 70*T);
    end

    // resets: presence delays sweep inside the window
    mode = 1; pres_w = 60;
    for (int d = 15; d <= 60; d += 15) begin
      pres_dly = d;
      run_op(2'd0, 1'b0);
      check(m_res == 1'b1, "R4 presence seen", int'(m_res), 1);
      check(m_pd == 500*T, "R3 reset low time", m_pd, 500*T);
      check(m_busy == 1000*T, "R3 reset total time", m_busy, 1000*T);
    end
    // no slave
    mode = 0;
    run_op(2'd0, 1'b1);
    check(m_res == 1'b0, "R4 no presence", int'(m_res), 0);
    // low before window
    mode = 1; pres_dly = 5; pres_w = 8;
    run_op(2'd0, 1'b0);
    check(m_res == 1'b0, "R4 early low ignored", int'(m_res), 0);
    // low after window
    pres_dly = 310; pres_w = 100;
    run_op(2'd0, 1'b0);
    check(m_res == 1'b0, "R4 late low ignored", int'(m_res), 0);

    // strong pullup hold, then a slot right after
    mode = 0;
    run_op(2'd3, 1'b0);
    check(m_spu == SPU_US*T, "R9 hold length", m_spu, SPU_US*T);
    check(m_pd == 0, "R9 no pull-low during hold", m_pd, 0);
    check(m_both == 0, "R10 no overlap", m_both, 0);
    run_op(2'd1, 1'b1);
    check(m_pd == 6*T, "R5 write after hold", m_pd, 6*T);
    check(m_spu == 0, "R10 hold off during slot", m_spu, 0);

    repeat (4) @(negedge clk_i);
    check(idle_bad == 0, "R10 outputs quiet while idle", idle_bad, 0);
    if (timeout) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule